// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block carries 9-bit words from a write clock domain to an unrelated read clock domain. The two pointers cross between the domains as Gray code through two-flop synchronizers. A mode input picks one of two read styles, and it is captured once, in the first read-clock cycle after reset.

- **Standard mode.** A read request returns the word on the next read-clock edge.
- **Fall-through mode.** The head word sits in an output register before it is requested, so the FIFO holds one word more than the memory.

A rewind pulse on the read side returns reading to the first word written since reset, so a short packet can be replayed. The write pointer does not move. A half-full output reports occupancy as seen from the read domain.

The write port is valid/ready. A word transfers on a write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` low means full, and the writer must hold off.

On the read port, `rd_valid` means data is available and `rd_ready` is the consumer's request. A read is accepted on a read-clock edge where both are high. The consumer applies back-pressure by keeping `rd_ready` low.

Between reset and a rewind, at most DEPTH-2 words may be written. This keeps the full flag static while the rewind takes effect.

Top module: `dcfifo_rt`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_ready` is 1, and `rd_valid` and `half_full` are 0.
- R2: In standard mode, `rd_valid` is high whenever stored words exist. An accepted read puts the oldest word on `rd_data` after the same read-clock edge. Words leave in the order they were written.
- R3: In standard mode, `wr_ready` falls after DEPTH words are stored without reads.
- R4: In fall-through mode, the oldest word appears on `rd_data` with `rd_valid` high without any request. While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R5: In fall-through mode, DEPTH+1 words are accepted before `wr_ready` falls.
- R6: A write attempted while `wr_ready` is low is ignored: no pointer moves and no extra word is ever read out.
- R7: In standard mode, a read request while `rd_valid` is low is ignored: `rd_data` holds and the read pointer does not move.
- R8: In standard mode, the read-clock cycle after a rewind pulse has `rd_valid` low. The next cycle has it high again, and reading restarts at the first word written since reset.
- R9: In fall-through mode, `rd_valid` is low for two read-clock cycles after a rewind pulse. It then rises with the first word written since reset already on `rd_data`.
- R10: `half_full` is high when more than DEPTH/2 words are held, counting the output register in fall-through mode. It is computed in the read domain.
- R11: The mode input (0 = standard, 1 = fall-through) is captured in the first read-clock cycle after reset. Later changes have no effect.
- R12: After reads free space in a full FIFO, `wr_ready` returns within a few write-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| fwft_sel | input | 1 | Read mode: 0 = standard, 1 = fall-through; captured after reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Space available (not full) |
| wr_data | input | DW | Write word |
| rd_ready | input | 1 | Read request / consumer ready |
| rd_valid | output | 1 | Data available (not empty / output ready) |
| rd_data | output | DW | Read word |
| rewind | input | 1 | Restart reading at the first word written since reset (read domain) |
| half_full | output | 1 | More than DEPTH/2 words held |

## Verification
Directed fills to the exact capacity of each mode show whether the output register is counted as storage. Attempts to write when full and read when empty show whether these attempts are ignored. Rewind is checked cycle by cycle in both modes, which separates the one-cycle and two-cycle recovery and checks the replayed data. Random enables on both sides, across unrelated clocks, check ordering against a queue model under back-pressure at both ends.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_ptr_xfer.sv
// Carries a binary pointer across domains: registered Gray in the source,
// a chain of synchronizer flops in the destination, decoded back to binary.
module fifo_ptr_xfer #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_q;
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_q;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    dst_bin[W-1] = stg[STAGES-1][W-1];
    for (int i = W-2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [AW:0] rbin_sync,
  output logic        wr_ready,
  output logic        push,
  output logic [AW:0] wbin
);
  logic [AW:0] used;

  // Pointer distance reaches DEPTH exactly when the memory is full.
  assign used     = wbin - rbin_sync;
  assign wr_ready = ~used[AW];
  assign push     = wr_valid & wr_ready;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)    wbin <= '0;
    else if (push) wbin <= wbin + 1'b1;
  end
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import fifo_rt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        rclk,
  input  logic        rst_n,
  input  logic        fwft_sel,
  input  logic        rd_ready,
  input  logic        rewind,
  input  logic [AW:0] wbin_sync,
  output logic        rd_valid,
  output logic        fetch,
  output logic [AW:0] rbin,
  output logic        mode_fwft,
  output logic        rt_busy,
  output logic        half_full
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  rd_mode_e    mode_q;
  logic        cfg_done;
  logic        out_full;
  logic [AW:0] core_cnt;
  logic        core_empty;
  logic [AW+1:0] occ;
  logic        std_valid;

  assign mode_fwft  = (mode_q == RD_FWFT);
  assign core_cnt   = wbin_sync - rbin;
  assign core_empty = (core_cnt == '0);
  assign std_valid  = cfg_done & ~core_empty & ~rt_busy;

  always_comb begin
    if (mode_fwft) fetch = cfg_done & ~core_empty & ~rt_busy & ~rewind & (~out_full | rd_ready);
    else           fetch = std_valid & rd_ready & ~rewind;
  end

  assign rd_valid  = mode_fwft ? out_full : std_valid;
  assign occ       = {1'b0, core_cnt} + {{(AW+1){1'b0}}, (mode_fwft & out_full)};
  assign half_full = (occ > (AW+2)'(HALF));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= RD_STD;
      cfg_done <= 1'b0;
      rbin     <= '0;
      out_full <= 1'b0;
      rt_busy  <= 1'b0;
    end else begin
      if (!cfg_done) begin
        cfg_done <= 1'b1;
        mode_q   <= fwft_sel ? RD_FWFT : RD_STD;
      end
      rt_busy <= rewind;
      if (rewind) begin
        rbin     <= '0;
        out_full <= 1'b0;
      end else begin
        if (fetch) rbin <= rbin + 1'b1;
        if (mode_fwft) begin
          if (fetch)         out_full <= 1'b1;
          else if (rd_ready) out_full <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dcfifo_rt.sv
module dcfifo_rt #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rewind,
  output logic          half_full
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, rbin, wbin_rs, rbin_ws;
  logic          push, fetch, mode_fwft, rt_busy;

  fifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_valid(wr_valid), .rbin_sync(rbin_ws),
    .wr_ready(wr_ready), .push(push), .wbin(wbin)
  );

  fifo_ptr_xfer #(.W(PW), .STAGES(2)) u_w2r (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .src_bin(wbin), .dst_bin(wbin_rs)
  );

  fifo_ptr_xfer #(.W(PW), .STAGES(2)) u_r2w (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .src_bin(rbin), .dst_bin(rbin_ws)
  );

  fifo_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .rd_ready(rd_ready),
    .rewind(rewind), .wbin_sync(wbin_rs), .rd_valid(rd_valid), .fetch(fetch),
    .rbin(rbin), .mode_fwft(mode_fwft), .rt_busy(rt_busy), .half_full(half_full)
  );

  fifo_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wclk), .we(push), .waddr(wbin[AW-1:0]), .wdata(wr_data),
    .rclk(rclk), .re(fetch), .raddr(rbin[AW-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/dcfifo_rt_chk.sv
module dcfifo_rt_chk #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW:0]   wbin,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          rewind,
  input logic [AW:0]   rbin,
  input logic          mode_fwft,
  input logic          rt_busy,
  input logic          half_full
);
  // R6
  no_full_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wbin));

  // R7
  no_empty_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_fwft && rd_ready && !rd_valid && !rewind) |=> ($stable(rbin) && $stable(rd_data)));

  // R4
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_fwft && rd_valid && !rd_ready && !rewind) |=> (rd_valid && $stable(rd_data)));

  // R8
  rewind_reset_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rewind |=> (!rd_valid && rbin == '0));

  // R9
  fwft_rewind_gap_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_fwft && rt_busy) |=> !rd_valid);

  // R10
  half_implies_data_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_fwft && half_full && !rt_busy) |-> rd_valid);
endmodule

bind dcfifo_rt dcfifo_rt_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wbin(wbin), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .rewind(rewind), .rbin(rbin), .mode_fwft(mode_fwft), .rt_busy(rt_busy),
  .half_full(half_full)
);

// File: tb/test_dcfifo_rt.sv
module test_dcfifo_rt;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0, fwft_sel = 0;
  logic wr_valid = 0, rd_ready = 0, rewind = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, half_full;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] model[$];
  logic [DW-1:0] hist[$];

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dcfifo_rt #(.DW(DW), .AW(AW)) i_dcfifo_rt (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rewind(rewind), .half_full(half_full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit half_expected(input int held);
    return held > DEPTH / 2;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset(input bit fw);
    rst_n = 0; fwft_sel = fw; wr_valid = 0; rd_ready = 0; rewind = 0;
    model.delete(); hist.delete();
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    check(wr_ready == 1 && rd_valid == 0 && half_full == 0, "R1 during reset",
          {wr_ready, rd_valid, half_full}, 3'b100);
    rst_n = 1;
  endtask

  // returns 1 when the word was accepted
  task automatic push(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wr_valid = 1; wr_data = d;
    acc = wr_ready;
    if (acc) begin model.push_back(d); hist.push_back(d); end
    @(negedge wclk);
    wr_valid = 0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    @(negedge rclk);
    while (!rd_valid && n < 40) begin @(negedge rclk); n++; end
    check(rd_valid == 1, req, rd_valid, 1);
  endtask

  task automatic pop_std(input string req);
    logic [DW-1:0] e;
    wait_valid(req);
    rd_ready = 1;
    @(negedge rclk);
    rd_ready = 0;
    e = model.pop_front();
    check(rd_data === e, req, rd_data, e);
  endtask

  task automatic pop_fwft(input string req);
    logic [DW-1:0] e;
    wait_valid(req);
    e = model.pop_front();
    check(rd_data === e, req, rd_data, e);
    rd_ready = 1;
    @(negedge rclk);
    rd_ready = 0;
  endtask

  task automatic pulse_rewind();
    @(negedge rclk);
    rewind = 1;
    @(negedge rclk);
    rewind = 0;
    model = hist;
  endtask

  task automatic random_phase(input bit fw, input int nwords);
    fork
      begin : writer
        int sent = 0;
        while (sent < nwords) begin
          @(negedge wclk);
          wr_valid = ($urandom % 3) != 0;
          wr_data = DW'($urandom);
          if (wr_valid && wr_ready) begin model.push_back(wr_data); sent++; end
        end
        @(negedge wclk);
        wr_valid = 0;
      end
      begin : reader
        int got = 0;
        bit pend = 0;
        logic [DW-1:0] e;
        while (got < nwords) begin
          @(negedge rclk);
          if (pend) begin
            e = model.pop_front();
            check(rd_data === e, "R2 random order", rd_data, e);
            got++; pend = 0;
          end
          rd_ready = ($urandom % 2) != 0;
          if (!fw) pend = rd_ready && rd_valid;
          else if (rd_ready && rd_valid && got < nwords) begin
            e = model.pop_front();
            check(rd_data === e, "R4 random order", rd_data, e);
            got++;
          end
        end
        rd_ready = 0;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    bit acc;
    int cnt;
    logic [DW-1:0] last;
    void'($urandom(32'd1234));

    // ---------------- standard mode: capacity, full and empty ----------
    do_reset(0);
    cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'($urandom), acc);
      cnt += acc;
    end
    check(cnt == DEPTH, "R3 accepted count", cnt, DEPTH);
    @(negedge wclk);
    check(wr_ready == 0, "R3 full after DEPTH", wr_ready, 0);
    push(9'h1AB, acc);
    check(acc == 0, "R6 write when full", acc, 0);
    repeat (6) @(negedge rclk);
    check(half_full == half_expected(DEPTH), "R10 high at full", half_full, 1);
    for (int i = 0; i < DEPTH / 2; i++) pop_std("R2 std order");
    cnt = 0;
    while (!wr_ready && cnt < 12) begin @(negedge wclk); cnt++; end
    check(wr_ready == 1, "R12 space returns", wr_ready, 1);
    repeat (2) @(negedge rclk);
    check(half_full == half_expected(DEPTH / 2), "R10 low at half", half_full, 0);
    while (model.size() > 0) pop_std("R6 no extra word, R2 order");
    @(negedge rclk);
    check(rd_valid == 0, "R2 empty", rd_valid, 0);
    last = rd_data;
    rd_ready = 1;
    @(negedge rclk);
    rd_ready = 0;
    check(rd_data === last && rd_valid == 0, "R7 read when empty", rd_data, last);
    push(9'h055, acc);
    pop_std("R7 pointer unchanged");
    repeat (3) @(negedge rclk);
    check(rd_valid == 0, "R7 still empty", rd_valid, 0);

    // ---------------- standard mode rewind ----------------
    do_reset(0);
    for (int i = 0; i < 5; i++) push(DW'(9'h100 + i), acc);
    pop_std("R2 before rewind");
    pop_std("R2 before rewind");
    pulse_rewind();
    check(rd_valid == 0, "R8 gap cycle", rd_valid, 0);
    @(negedge rclk);
    check(rd_valid == 1, "R8 valid again", rd_valid, 1);
    for (int i = 0; i < 5; i++) pop_std("R8 replay order");

    do_reset(0);
    random_phase(0, 300);

    // ---------------- fall-through mode ----------------
    do_reset(1);
    repeat (2) @(negedge rclk);
    fwft_sel = 0;   // R11: must be ignored now
    push(9'h0C3, acc);
    repeat (8) @(negedge rclk);
    check(rd_valid == 1 && rd_data === 9'h0C3, "R4 R11 fall-through head", rd_data, 9'h0C3);
    repeat (3) @(negedge rclk);
    check(rd_valid == 1 && rd_data === 9'h0C3, "R4 held without request", rd_data, 9'h0C3);
    cnt = 1;
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'($urandom), acc);
      cnt += acc;
    end
    check(cnt == DEPTH + 1, "R5 accepted count", cnt, DEPTH + 1);
    @(negedge wclk);
    check(wr_ready == 0, "R5 full after DEPTH+1", wr_ready, 0);
    push(9'h1FF, acc);
    check(acc == 0, "R6 write when full fwft", acc, 0);
    repeat (6) @(negedge rclk);
    check(half_full == half_expected(DEPTH + 1), "R10 fwft high", half_full, 1);
    while (model.size() > 0) pop_fwft("R5 fwft order");
    repeat (4) @(negedge rclk);
    check(rd_valid == 0 && half_full == 0, "R4 R10 drained", {rd_valid, half_full}, 0);

    // ---------------- fall-through rewind ----------------
    do_reset(1);
    for (int i = 0; i < 4; i++) push(DW'(9'h0A0 + i), acc);
    pop_fwft("R4 before rewind");
    repeat (3) @(negedge rclk);
    pulse_rewind();
    check(rd_valid == 0, "R9 gap 1", rd_valid, 0);
    @(negedge rclk);
    check(rd_valid == 0, "R9 gap 2", rd_valid, 0);
    @(negedge rclk);
    check(rd_valid == 1 && rd_data === hist[0], "R9 first word back", rd_data, hist[0]);
    for (int i = 0; i < 4; i++) pop_fwft("R9 replay order");

    do_reset(1);
    random_phase(1, 300);

    repeat (4) @(negedge rclk);
    finish_run();
  end
endmodule